// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain DMA Engine

This block moves data between a 32-bit data FIFO and a word-wide memory. It does not take one address and a length. It follows a chain of descriptors that live in the same memory. Each descriptor is two 32-bit words. The first word is an attribute word that carries the flags, an action code and a byte length. The second word is an address. Software builds the chain, places the first descriptor's address on `desc_base`, chooses the direction with `to_fifo` and pulses `start`. The engine then fetches, decodes and acts on each descriptor in turn until it reaches one marked as last.

A transfer descriptor moves its length in 32-bit words through the buffer at its address. When `to_fifo` is 1, data is read from memory and pushed into the FIFO. When `to_fifo` is 0, data is popped from the FIFO and written to memory. A link descriptor sends the next fetch to its address. A no-op descriptor only moves on to the next descriptor. The block reports a finished chain with `done`, a descriptor flagged for notification with `dma_irq`, and a malformed descriptor with `err`.

The memory port is a fixed-latency port with no stall. Read data appears on `mem_rdata` in the cycle after the request and holds until the next read. A write completes in the cycle it is requested. The FIFO port is show-ahead: `fifo_rdata` is valid while `fifo_empty` is low.

Top module: `sg_chain_dma`

## Requirements
- R1: After reset the engine is idle. `busy`, `mem_req`, `fifo_wr`, `fifo_rd`, `done`, `dma_irq` and `err` are all low.
- R2: A `start` pulse seen while idle begins a fetch. In the next cycle the engine reads the attribute word at the descriptor pointer. In the cycle after that it reads the address word at pointer+4. A decode cycle with no memory request follows. The two low bits of every descriptor and buffer address are treated as zero.
- R3: Attribute word decode. Bit 0 is valid, bit 1 is last-in-chain and bit 2 is notify. Bits 5:4 are the action: 0 and 1 are no-op, 2 is transfer and 3 is link. Bits 31:16 are the byte length.
- R4: A descriptor whose valid bit is 0 makes `err` high for exactly one cycle. In that same cycle the engine returns to idle, and it makes no further memory access.
- R5: Memory-to-FIFO transfer (`to_fifo`=1). For each word the engine reads memory one cycle. It then pushes the returned word with `fifo_wr` in the first following cycle in which `fifo_full` is low, and waits while `fifo_full` is high. Words go from consecutive addresses starting at the buffer address. `fifo_wr` and `fifo_rd` are never high together.
- R6: FIFO-to-memory transfer (`to_fifo`=0). In each cycle in which `fifo_empty` is low, the engine pops one word with `fifo_rd` and writes it to the next consecutive buffer address in the same cycle.
- R7: A transfer moves length bits 15:2 words. The two low length bits are ignored. A word count of zero means 16384 words (65536 bytes).
- R8: After a descriptor that is not last, the next descriptor is fetched from the current pointer+8, unless R9 applies.
- R9: A link descriptor that is not last sends the next fetch to its address word.
- R10: When the last descriptor completes, `done` is high for exactly one cycle, in the cycle after completion. The engine is idle in that cycle. A transfer completes on its final word. Other actions complete in their decode cycle.
- R11: A descriptor with the notify bit makes `dma_irq` high for one cycle, in the cycle after that descriptor completes.
- R12: A `start` pulse while busy is ignored, and the running chain continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking a chain (sampled while idle) |
| desc_base | input | AW | Address of the first descriptor |
| to_fifo | input | 1 | 1: memory to FIFO, 0: FIFO to memory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (with mem_req) |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| fifo_wr | output | 1 | Push mem_rdata word into the FIFO |
| fifo_wdata | output | 32 | FIFO push data |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_rd | output | 1 | Pop the FIFO word |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO holds no word |
| busy | output | 1 | A chain is being processed |
| done | output | 1 | One-cycle pulse: chain finished |
| dma_irq | output | 1 | One-cycle pulse: notify descriptor finished |
| err | output | 1 | One-cycle pulse: invalid descriptor |

## Verification
The bench drives chains that mix no-op, reserved, link and transfer entries in both directions. The FIFO full and empty inputs toggle with a fixed cycle pattern, so that words stall partway through a run. The bench also uses a zero length field. A decoder that took zero as zero words would end that transfer after no data and fail the word count. It further runs a link entry that also carries the last flag. An engine that jumped instead of stopping would go on fetching and miss the `done` cycle. A pointer that advanced by four, or a link that was ignored, would show up as a wrong fetch address in the per-cycle comparison. A `start` pulse in the middle of a run would reset the pointer, and an engine that accepted it would diverge from the model. An invalid entry placed after a valid transfer shows whether the engine stops cleanly with one error cycle or makes more memory accesses.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ATTR,
    ST_ADDR,
    ST_EVAL,
    ST_MRD,
    ST_PUSH,
    ST_POP
  } eng_state_e;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'd0,
    ACT_RSV  = 2'd1,
    ACT_XFER = 2'd2,
    ACT_LINK = 2'd3
  } act_e;

  typedef struct packed {
    logic valid;
    logic last;
    logic notify;
    act_e act;
  } desc_flags_t;

endpackage

// File: rtl/sgdma_rst_sync.sv
`timescale 1ns/1ps
module sgdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sgdma_desc_decode.sv
`timescale 1ns/1ps
module sgdma_desc_decode
  import sgdma_pkg::*;
#(
  parameter int LENW = 16,
  localparam int CW  = LENW - 1
) (
  input  logic [WORD_W-1:0] attr_word,
  output desc_flags_t       flags,
  output logic [CW-1:0]     words
);

  localparam int WCW = LENW - 2;

  logic [WCW-1:0] wfield;

  assign flags.valid  = attr_word[0];
  assign flags.last   = attr_word[1];
  assign flags.notify = attr_word[2];
  assign flags.act    = act_e'(attr_word[5:4]);

  // length lives in the top LENW bits; byte bits below a word are dropped
  assign wfield = attr_word[WORD_W-1 -: WCW];

  always_comb begin
    if (wfield == '0) words = {1'b1, {WCW{1'b0}}};
    else              words = {1'b0, wfield};
  end

endmodule

// File: rtl/sgdma_xfer_ctr.sv
`timescale 1ns/1ps
module sgdma_xfer_ctr #(
  parameter int AW = 32,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_words,
  output logic [AW-1:0] cur_addr,
  output logic          last
);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    addr_d = addr_q;
    left_d = left_q;
    if (load) begin
      addr_d = {load_addr[AW-1:2], 2'b00};
      left_d = load_words;
    end else if (step) begin
      addr_d = addr_q + AW'(4);
      left_d = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load || step) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign cur_addr = addr_q;
  assign last     = (left_q == CW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left_q != '0)); // R7

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q != '0)); // R7

endmodule

// File: rtl/sg_chain_dma.sv
`timescale 1ns/1ps
module sg_chain_dma
  import sgdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] desc_base,
  input  logic          to_fifo,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          fifo_wr,
  output logic [31:0]   fifo_wdata,
  input  logic          fifo_full,
  output logic          fifo_rd,
  input  logic [31:0]   fifo_rdata,
  input  logic          fifo_empty,
  output logic          busy,
  output logic          done,
  output logic          dma_irq,
  output logic          err
);

  localparam int CW = LENW - 1;

  logic              rst_sync_n;
  eng_state_e        state_q, state_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [WORD_W-1:0] attr_q, attr_d;
  logic              dir_q, dir_d;
  logic              done_q, done_d, irq_q, irq_d, err_q, err_d;
  logic              ctr_load, ctr_step, ctr_last, desc_fin;
  logic [AW-1:0]     cur_addr, link_addr;
  desc_flags_t       flags;
  logic [CW-1:0]     words;

  sgdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sgdma_desc_decode #(.LENW(LENW)) u_dec (
    .attr_word(attr_q), .flags(flags), .words(words)
  );

  sgdma_xfer_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_sync_n), .load(ctr_load), .step(ctr_step),
    .load_addr(mem_rdata[AW-1:0]), .load_words(words),
    .cur_addr(cur_addr), .last(ctr_last)
  );

  assign link_addr = {mem_rdata[AW-1:2], 2'b00};

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    attr_d     = attr_q;
    dir_d      = dir_q;
    done_d     = 1'b0;
    irq_d      = 1'b0;
    err_d      = 1'b0;
    ctr_load   = 1'b0;
    ctr_step   = 1'b0;
    desc_fin   = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    fifo_wr    = 1'b0;
    fifo_rd    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ptr_d   = {desc_base[AW-1:2], 2'b00};
          dir_d   = to_fifo;
          state_d = ST_ATTR;
        end
      end
      ST_ATTR: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q;
        state_d  = ST_ADDR;
      end
      ST_ADDR: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(4);
        attr_d   = mem_rdata;
        state_d  = ST_EVAL;
      end
      ST_EVAL: begin
        if (!flags.valid) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (flags.act == ACT_XFER) begin
          ctr_load = 1'b1;
          state_d  = dir_q ? ST_MRD : ST_POP;
        end else begin
          desc_fin = 1'b1;
        end
      end
      ST_MRD: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr;
        state_d  = ST_PUSH;
      end
      ST_PUSH: begin
        if (!fifo_full) begin
          fifo_wr  = 1'b1;
          ctr_step = 1'b1;
          if (ctr_last) desc_fin = 1'b1;
          else          state_d  = ST_MRD;
        end
      end
      ST_POP: begin
        if (!fifo_empty) begin
          fifo_rd  = 1'b1;
          mem_req  = 1'b1;
          mem_we   = 1'b1;
          mem_addr = cur_addr;
          ctr_step = 1'b1;
          if (ctr_last) desc_fin = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (desc_fin) begin
      irq_d = flags.notify;
      if (flags.last) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = ST_ATTR;
        if (state_q == ST_EVAL && flags.act == ACT_LINK) ptr_d = link_addr;
        else                                             ptr_d = ptr_q + AW'(8);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      attr_q  <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      attr_q  <= attr_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign dma_irq    = irq_q;
  assign err        = err_q;
  assign mem_wdata  = fifo_rdata;
  assign fifo_wdata = mem_rdata;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !(mem_req || fifo_wr || fifo_rd)); // R1

  AST_ADDR_AFTER_ATTR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ATTR) |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + AW'(4))); // R2

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err |-> (!busy && !mem_req)); // R4

  AST_ONE_FIFO_DIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fifo_wr && fifo_rd)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> $stable(dir_q)); // R12

endmodule

// File: tb/sim_sg_chain_dma.sv
`timescale 1ns/1ps
module sim_sg_chain_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] desc_base = '0;
  logic        to_fifo = 1'b0;
  logic        mem_req, mem_we, fifo_wr, fifo_rd, busy, done, dma_irq, err;
  logic [31:0] mem_addr, mem_wdata, fifo_wdata, fifo_rdata;
  logic [31:0] mem_rdata = '0;
  logic        fifo_full, fifo_empty;

  always #10 clk = ~clk;

  sg_chain_dma #(.AW(32), .LENW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base), .to_fifo(to_fifo),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .busy(busy), .done(done), .dma_irq(dma_irq), .err(err)
  );

  // behavioural environment
  logic [31:0] mem [0:32767];
  int cyc = 0;
  int pops = 0;
  int fmode = 0;
  int n_run = 0, n_fail = 0;
  int n_done = 0, n_irq = 0, n_err = 0;
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] wa_q[$];
  logic [31:0] wd_q[$];
  int model_pops = 0;

  assign fifo_full  = (fmode != 0) && ((cyc % 4) == 1 || (cyc % 7) == 3);
  assign fifo_empty = (fmode != 0) && ((cyc % 5) == 2);
  assign fifo_rdata = 32'hA500_0000 + 32'(pops);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we) mem[mem_addr[16:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[16:2]];
    if (fifo_wr && !fifo_full) got_q.push_back(fifo_wdata);
    if (fifo_rd && !fifo_empty) pops <= pops + 1;
  end

  // expected values for the current cycle
  logic exp_busy = 0, exp_req = 0, exp_we = 0, exp_fwr = 0, exp_frd = 0;
  logic exp_done = 0, exp_irq = 0, exp_err = 0;
  logic [31:0] exp_addr = '0, exp_wdata = '0, exp_fdata = '0;
  logic pend_done = 0, pend_irq = 0, pend_err = 0;
  logic chk_en = 0;

  task automatic fail(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) fail(req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (done) n_done++;
    if (dma_irq) n_irq++;
    if (err) n_err++;
    if (chk_en) begin
      n_run++;
      if (busy !== exp_busy) fail("R12", "busy", 32'(busy), 32'(exp_busy));
      if (mem_req !== exp_req) fail("R2", "mem_req", 32'(mem_req), 32'(exp_req));
      if (exp_req && mem_addr !== exp_addr) fail("R2", "mem_addr", mem_addr, exp_addr);
      if (exp_req && mem_we !== exp_we) fail("R6", "mem_we", 32'(mem_we), 32'(exp_we));
      if (exp_req && exp_we && mem_wdata !== exp_wdata) fail("R6", "mem_wdata", mem_wdata, exp_wdata);
      if (fifo_wr !== exp_fwr) fail("R5", "fifo_wr", 32'(fifo_wr), 32'(exp_fwr));
      if (exp_fwr && fifo_wdata !== exp_fdata) fail("R5", "fifo_wdata", fifo_wdata, exp_fdata);
      if (fifo_rd !== exp_frd) fail("R6", "fifo_rd", 32'(fifo_rd), 32'(exp_frd));
      if (done !== exp_done) fail("R10", "done", 32'(done), 32'(exp_done));
      if (dma_irq !== exp_irq) fail("R11", "dma_irq", 32'(dma_irq), 32'(exp_irq));
      if (err !== exp_err) fail("R4", "err", 32'(err), 32'(exp_err));
    end
  end

  task automatic nxt;
    @(posedge clk);
    #1;
    exp_done = pend_done; exp_irq = pend_irq; exp_err = pend_err;
    pend_done = 0; pend_irq = 0; pend_err = 0;
  endtask

  task automatic quiet(input logic b);
    exp_busy = b; exp_req = 0; exp_we = 0; exp_fwr = 0; exp_frd = 0;
  endtask

  function automatic logic [31:0] mk(input int len, input int act, input bit last,
                                     input bit notify, input bit valid);
    return (32'(len) << 16) | (32'(act) << 4) | (32'(notify) << 2) | (32'(last) << 1) | 32'(valid);
  endfunction

  task automatic put_desc(input logic [31:0] at, input logic [31:0] attr, input logic [31:0] adr);
    mem[at[16:2]] = attr;
    mem[at[16:2] + 1] = adr;
  endtask

  // reference walk of a chain, one expectation set per clock
  task automatic model_chain(input logic [31:0] base, input bit dir);
    logic [31:0] ptr, attr, ba, a;
    int words;
    bit fin, moved;
    @(negedge clk);
    start = 1; desc_base = base; to_fifo = dir;
    nxt();
    start = 0;
    ptr = base & ~32'h3;
    fin = 0;
    while (!fin) begin
      quiet(1); exp_req = 1; exp_addr = ptr; nxt();
      quiet(1); exp_req = 1; exp_addr = ptr + 4; nxt();
      attr = mem[ptr[16:2]];
      ba = mem[ptr[16:2] + 1];
      quiet(1);
      if (!attr[0]) begin
        pend_err = 1;                                   // R4
        fin = 1;
      end else if (attr[5:4] == 2'd2) begin
        words = int'(attr[31:18]);
        if (words == 0) words = 16384;                  // R7
        nxt();
        for (int i = 0; i < words; i++) begin
          a = (ba & ~32'h3) + 32'(4 * i);
          if (dir) begin
            quiet(1); exp_req = 1; exp_addr = a; nxt();
            do begin
              quiet(1);
              moved = !fifo_full;
              exp_fwr = moved; exp_fdata = mem[a[16:2]];
              if (moved) exp_q.push_back(mem[a[16:2]]);
              if (moved && i == words - 1) begin
                pend_irq = attr[2];
                if (attr[1]) begin pend_done = 1; fin = 1; end
                else ptr = ptr + 8;
              end
              if (!(moved && i == words - 1)) nxt();
            end while (!moved);
          end else begin
            do begin
              quiet(1);
              moved = !fifo_empty;
              exp_frd = moved; exp_req = moved; exp_we = 1; exp_addr = a;
              exp_wdata = 32'hA500_0000 + 32'(model_pops);
              if (moved) begin
                wa_q.push_back(a); wd_q.push_back(exp_wdata); model_pops++;
              end
              if (moved && i == words - 1) begin
                pend_irq = attr[2];
                if (attr[1]) begin pend_done = 1; fin = 1; end
                else ptr = ptr + 8;
              end
              if (!(moved && i == words - 1)) nxt();
            end while (!moved);
          end
        end
      end else begin
        pend_irq = attr[2];                             // R11
        if (attr[1]) begin pend_done = 1; fin = 1; end
        else if (attr[5:4] == 2'd3) ptr = ba & ~32'h3;  // R9
        else ptr = ptr + 8;                             // R8, R3 (actions 0 and 1)
      end
      nxt();
    end
    quiet(0);
  endtask

  task automatic glitch_start(input int after);
    repeat (after) @(negedge clk);
    start = 1; desc_base = 32'h0000_0700; to_fifo = 0;   // R12: must be ignored
    @(negedge clk);
    start = 0;
  endtask

  task automatic settle;
    repeat (4) nxt();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int base_fails;
    for (int i = 0; i < 32768; i++) mem[i] = 32'h1000_0000 + 32'(i * 37);

    // R1: idle outputs while reset is held and after release
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !fifo_wr && !fifo_rd && !done && !dma_irq && !err,
          "R1", "outputs in reset", {busy, mem_req, fifo_wr, fifo_rd, done, dma_irq, err}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!busy && !mem_req && !done && !err, "R1", "outputs after release",
          {busy, mem_req, done, err}, 0);
    chk_en = 1;

    // scenario A: memory to FIFO, full stalls, notify+last, start while busy (R5, R10, R11, R12)
    fmode = 1;
    put_desc(32'h100, mk(32, 2, 1, 1, 1), 32'h1000);
    fork
      model_chain(32'h100, 1);
      glitch_start(9);
    join
    settle();
    check(got_q.size() == exp_q.size(), "R5", "words pushed", got_q.size(), exp_q.size());
    check(got_q.size() == 8, "R12", "chain length after ignored start", got_q.size(), 8);
    base_fails = 0;
    foreach (exp_q[i]) if (i < got_q.size() && got_q[i] !== exp_q[i]) base_fails++;
    check(base_fails == 0, "R5", "pushed data", base_fails, 0);

    // scenario B: FIFO to memory; no-op, transfer, link, reserved+notify, transfer (R3, R6, R7, R8, R9)
    put_desc(32'h200, mk(0, 0, 0, 0, 1), 32'hDEAD_0000);
    put_desc(32'h208, mk(14, 2, 0, 0, 1), 32'h2000);     // 14 bytes -> 3 words (R7)
    put_desc(32'h210, mk(0, 3, 0, 0, 1), 32'h300);       // link (R9)
    put_desc(32'h300, mk(0, 1, 0, 1, 1), 32'h0);         // reserved action acts as no-op (R3)
    put_desc(32'h308, mk(20, 2, 1, 1, 1), 32'h2102);     // low address bits ignored (R2)
    model_chain(32'h200, 0);
    settle();
    check(wa_q.size() == 8, "R7", "words written for 14+20 bytes", wa_q.size(), 8);
    check(wa_q.size() > 3 && wa_q[3] == 32'h2100, "R9", "first word after link", wa_q.size() > 3 ? wa_q[3] : 0, 32'h2100);
    base_fails = 0;
    foreach (wa_q[i]) if (mem[wa_q[i][16:2]] !== wd_q[i]) base_fails++;
    check(base_fails == 0, "R6", "memory contents", base_fails, 0);
    check(mem[32'h200C >> 2] == 32'h1000_0000 + 32'((32'h200C >> 2) * 37), "R8", "word past buffer untouched",
          mem[32'h200C >> 2], 32'h1000_0000 + 32'((32'h200C >> 2) * 37));

    // scenario C: transfer then an invalid entry (R4, R8)
    fmode = 0;
    put_desc(32'h400, mk(8, 2, 0, 0, 1), 32'h1100);
    put_desc(32'h408, 32'h0000_0026, 32'h1200);           // valid bit clear
    model_chain(32'h400, 1);
    settle();
    check(n_err == 1, "R4", "error pulses", n_err, 1);

    // scenario D: zero length means 16384 words (R7)
    wa_q.delete(); wd_q.delete();
    put_desc(32'h500, mk(0, 2, 1, 0, 1), 32'h10000);
    model_chain(32'h500, 0);
    settle();
    check(wa_q.size() == 16384, "R7", "words for zero length", wa_q.size(), 16384);
    check(mem[32'h1FFFC >> 2] == wd_q[16383], "R7", "last word of 64 KiB", mem[32'h1FFFC >> 2], wd_q[16383]);

    // scenario E: link carrying last stops; misaligned base (R2, R10, R11)
    put_desc(32'h600, mk(0, 3, 1, 1, 1), 32'h100);
    model_chain(32'h603, 0);
    settle();

    check(n_done == 4, "R10", "done pulses", n_done, 4);
    check(n_irq == 4, "R11", "notify pulses", n_irq, 4);
    check(!busy, "R10", "idle at end", 32'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule